// File: doc/BRIEF.md
# Debug Trigger Extra-Register Bank

This block holds the per-trigger configuration storage that a hart's debug trigger unit exposes through its control and status registers. A single CSR-style port reaches four registers: a trigger index, and three data registers (a control word, a match-data word and a context-extra word). The three data registers always refer to the trigger that the index currently selects. Address and data comparison and trigger firing are handled elsewhere. This block only stores the fields, legalizes them and returns them.

The context-extra word carries hypervisor and supervisor context-match fields. Their legal values depend on whether the hypervisor and supervisor extensions are present. A trigger whose debug-ownership bit is set can only be rewritten while the hart is in debug mode. Writing a control word also rewrites the trigger's context-extra word from its current read view, so the word is re-legalized under the extension settings at that moment. Each write produces a one-cycle accepted or blocked pulse.

Top module: `dbg_trig_bank`

## Requirements
- R1: Address 0 is the index. A written value at or above the trigger count (default 4) stores as count-1. Addresses 1, 2 and 3 (control, match data, context extra) read and write only the trigger selected by the index.
- R2: Context-extra layout: hypervisor value [31:26], hypervisor select [25:23], byte mask [19:18], supervisor value [17:2], supervisor select [1:0]. Bits [22:20] always read 0.
- R3: Hypervisor select reads back as 2 or 6 only when that value is stored and the hypervisor extension is present. In every other case it reads 0. This is evaluated at read time.
- R4: A written supervisor value stores as 0 when the supervisor extension is absent.
- R5: Supervisor select keeps the value 2 (asid) only when it is written with 2 while the supervisor extension is present. Every other write stores 0.
- R6: Control-word layout: ownership (dmode) bit 27, action [15:12], chain bit 11, all other bits 0. A written action above 4 stores as 0. A written action of 1 (enter debug) together with dmode 0 also stores as 0.
- R7: A control write with dmode 0 stores chain as 0 when the next-higher trigger has dmode set. The last trigger has no next-higher trigger and keeps the written chain bit.
- R8: A write to address 1, 2 or 3 is refused and leaves all state unchanged when the selected trigger's dmode is 1 and the debug-mode input is 0. Index writes are never refused.
- R9: An accepted control write rewrites the selected trigger's context-extra word from its current read view, applying R3 to R5 under the extension inputs at that moment.
- R10: In the cycle after the clock edge that takes a write, wr_ok pulses if the write was accepted and wr_blocked pulses if it was refused. The two pulses never occur together.
- R11: After reset, the index, every control word, every match-data word and every context-extra word read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_valid | input | 1 | Access strobe |
| csr_write | input | 1 | 1 = write, 0 = read |
| csr_addr | input | 2 | 0 index, 1 control, 2 match data, 3 context extra |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read view of the addressed register (combinational) |
| in_debug | input | 1 | Hart is in debug mode |
| hyp_present | input | 1 | Hypervisor extension present |
| sup_present | input | 1 | Supervisor extension present |
| wr_ok | output | 1 | One-cycle pulse: write accepted |
| wr_blocked | output | 1 | One-cycle pulse: write refused |

## Verification
The read data path is combinational. After a write edge, its effect is visible in csr_rdata at the next falling edge, so the bench samples reads at a falling edge while the address is held. The wr_ok and wr_blocked pulses come from a register one stage after the write edge. The bench checks them at the falling edge that directly follows that edge, before the next rising edge clears them. The hypervisor-select view depends on hyp_present at read time, with no delay. The bench therefore flips that input between writes and re-reads the register, which separates read-time legalization from write-time legalization.

// File: rtl/dbg_trig_pkg.sv
// Package: shared field layouts, types and legalization functions for the
// debug trigger register bank. Assumes a 32-bit register width.
package dbg_trig_pkg;

    localparam int CSR_W = 32;

    // Register selection on the access port.
    typedef enum logic [1:0] {
        SEL_INDEX = 2'd0,
        SEL_CTRL  = 2'd1,
        SEL_MDATA = 2'd2,
        SEL_EXTRA = 2'd3
    } csr_sel_e;

    // Control-word field positions.
    localparam int CTL_DMODE_BIT = 27;
    localparam int CTL_ACT_LSB   = 12;
    localparam int CTL_ACT_W     = 4;
    localparam int CTL_CHAIN_BIT = 11;

    // Action codes.
    localparam logic [CTL_ACT_W-1:0] ACT_BREAK_EXC = 4'd0;
    localparam logic [CTL_ACT_W-1:0] ACT_ENTER_DBG = 4'd1;
    localparam logic [CTL_ACT_W-1:0] ACT_MAX       = 4'd4;

    // Context-extra field positions and widths.
    localparam int HVAL_LSB = 26;
    localparam int HVAL_W   = 6;
    localparam int HSEL_LSB = 23;
    localparam int HSEL_W   = 3;
    localparam int BMSK_LSB = 18;
    localparam int BMSK_W   = 2;
    localparam int SVAL_LSB = 2;
    localparam int SVAL_W   = 16;
    localparam int SSEL_LSB = 0;
    localparam int SSEL_W   = 2;

    // Supervisor select codes.
    localparam logic [SSEL_W-1:0] SSEL_IGNORE = 2'd0;
    localparam logic [SSEL_W-1:0] SSEL_ASID   = 2'd2;

    typedef struct packed {
        logic                 dmode;
        logic [CTL_ACT_W-1:0] action;
        logic                 chain;
    } ctl_t;

    typedef struct packed {
        logic [HVAL_W-1:0] hval;
        logic [HSEL_W-1:0] hsel;
        logic [BMSK_W-1:0] bmask;
        logic [SVAL_W-1:0] sval;
        logic [SSEL_W-1:0] ssel;
    } ext_t;

    // Place extra fields into a register word.
    function automatic logic [CSR_W-1:0] ext_pack(input ext_t e);
        logic [CSR_W-1:0] w;
        w = '0;
        w[HVAL_LSB +: HVAL_W] = e.hval;
        w[HSEL_LSB +: HSEL_W] = e.hsel;
        w[BMSK_LSB +: BMSK_W] = e.bmask;
        w[SVAL_LSB +: SVAL_W] = e.sval;
        w[SSEL_LSB +: SSEL_W] = e.ssel;
        return w;
    endfunction

    // Legalize a written word into stored extra fields.
    function automatic ext_t ext_wlegal(input logic [CSR_W-1:0] w, input logic sup);
        ext_t e;
        e.hval  = w[HVAL_LSB +: HVAL_W];
        e.hsel  = w[HSEL_LSB +: HSEL_W];
        e.bmask = w[BMSK_LSB +: BMSK_W];
        e.sval  = sup ? w[SVAL_LSB +: SVAL_W] : '0;
        e.ssel  = (sup && (w[SSEL_LSB +: SSEL_W] == SSEL_ASID)) ? SSEL_ASID : SSEL_IGNORE;
        return e;
    endfunction

    // Legalize stored fields for reading (hypervisor select).
    function automatic ext_t ext_rview(input ext_t e, input logic hyp);
        ext_t r;
        r = e;
        if (!(hyp && (e.hsel == 3'd2 || e.hsel == 3'd6))) begin
            r.hsel = '0;
        end
        return r;
    endfunction

    // Legalize a written action against the new ownership bit.
    function automatic logic [CTL_ACT_W-1:0] act_legal(input logic [CTL_ACT_W-1:0] a,
                                                        input logic dm);
        if (a > ACT_MAX || (a == ACT_ENTER_DBG && !dm)) begin
            return ACT_BREAK_EXC;
        end
        return a;
    endfunction

    // Place control fields into a register word.
    function automatic logic [CSR_W-1:0] ctl_pack(input ctl_t c);
        logic [CSR_W-1:0] w;
        w = '0;
        w[CTL_DMODE_BIT]               = c.dmode;
        w[CTL_ACT_LSB +: CTL_ACT_W]    = c.action;
        w[CTL_CHAIN_BIT]               = c.chain;
        return w;
    endfunction

endpackage

// File: rtl/dbg_trig_index.sv
// Module: trigger index register. Stores the selected trigger number and
// clamps out-of-range writes to the highest trigger. Assumes NTRIG >= 1.
module dbg_trig_index #(
    parameter int NTRIG = 4,
    parameter int IDX_W = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [dbg_trig_pkg::CSR_W-1:0] wdata,
    output logic [IDX_W-1:0]               idx_o
);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NTRIG - 1);

    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] idx_next;

    // Clamp the written value to an existing trigger.
    always_comb begin
        if (wdata >= dbg_trig_pkg::CSR_W'(NTRIG)) begin
            idx_next = IDX_LAST;
        end else begin
            idx_next = wdata[IDX_W-1:0];
        end
    end

    // Hold the index; load it on an index write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (wr_en) begin
            idx_q <= idx_next;
        end
    end

    assign idx_o = idx_q;
endmodule

// File: rtl/dbg_trig_slot.sv
// Module: storage for one trigger: control word, match data, context extra.
// Applies the write legalization and the read-time hypervisor select view.
// Assumes the caller has already resolved the ownership block and selection.
module dbg_trig_slot (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_ctl,
    input  logic                           wr_mdat,
    input  logic                           wr_ext,
    input  logic [dbg_trig_pkg::CSR_W-1:0] wdata,
    input  logic                           next_dmode,
    input  logic                           hyp_present,
    input  logic                           sup_present,
    output dbg_trig_pkg::ctl_t             ctl_o,
    output logic [dbg_trig_pkg::CSR_W-1:0] mdat_o,
    output logic [dbg_trig_pkg::CSR_W-1:0] ext_rd_o
);
    import dbg_trig_pkg::*;

    ctl_t             ctl_q;
    ctl_t             ctl_new;
    logic [CSR_W-1:0] mdat_q;
    ext_t             ext_q;
    ext_t             ext_view;

    // Read view of the extra word under the current hypervisor setting.
    always_comb begin
        ext_view = ext_rview(ext_q, hyp_present);
    end

    // Legalize an incoming control word.
    always_comb begin
        ctl_new.dmode  = wdata[CTL_DMODE_BIT];
        ctl_new.action = act_legal(wdata[CTL_ACT_LSB +: CTL_ACT_W], wdata[CTL_DMODE_BIT]);
        ctl_new.chain  = wdata[CTL_CHAIN_BIT] && !(!wdata[CTL_DMODE_BIT] && next_dmode);
    end

    // Control word register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (wr_ctl) begin
            ctl_q <= ctl_new;
        end
    end

    // Match-data register (stored as written).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mdat_q <= '0;
        end else if (wr_mdat) begin
            mdat_q <= wdata;
        end
    end

    // Extra register: direct write, or re-legalization on a control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_q <= '0;
        end else if (wr_ext) begin
            ext_q <= ext_wlegal(wdata, sup_present);
        end else if (wr_ctl) begin
            ext_q <= ext_wlegal(ext_pack(ext_view), sup_present);
        end
    end

    assign ctl_o    = ctl_q;
    assign mdat_o   = mdat_q;
    assign ext_rd_o = ext_pack(ext_view);
endmodule

// File: rtl/dbg_trig_bank.sv
// Module: top of the debug trigger register bank. Decodes the access port,
// applies the debug-ownership write block, routes data accesses through the
// index to one trigger slot, muxes read data and produces write pulses.
// Assumes reads are combinational and writes take effect at the clock edge.
module dbg_trig_bank #(
    parameter int NTRIG = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        csr_valid,
    input  logic        csr_write,
    input  logic [1:0]  csr_addr,
    input  logic [31:0] csr_wdata,
    output logic [31:0] csr_rdata,
    input  logic        in_debug,
    input  logic        hyp_present,
    input  logic        sup_present,
    output logic        wr_ok,
    output logic        wr_blocked
);
    import dbg_trig_pkg::*;

    localparam int IDX_W = (NTRIG > 1) ? $clog2(NTRIG) : 1;

    logic [IDX_W-1:0] idx_q;
    logic             wr_req;
    logic             wr_data_reg;
    logic             sel_dmode;
    logic             blocked;
    logic             accept;

    ctl_t             ctl_arr  [NTRIG];
    logic [CSR_W-1:0] mdat_arr [NTRIG];
    logic [CSR_W-1:0] ext_arr  [NTRIG];
    logic [NTRIG-1:0] dmode_vec;
    logic [NTRIG-1:0] next_dm;

    // Ownership decision for the selected trigger.
    always_comb begin
        wr_req      = csr_valid && csr_write;
        wr_data_reg = csr_addr != SEL_INDEX;
        sel_dmode   = ctl_arr[idx_q].dmode;
        blocked     = wr_req && wr_data_reg && sel_dmode && !in_debug;
        accept      = wr_req && !blocked;
    end

    dbg_trig_index #(
        .NTRIG (NTRIG),
        .IDX_W (IDX_W)
    ) u_index (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (accept && (csr_addr == SEL_INDEX)),
        .wdata (csr_wdata),
        .idx_o (idx_q)
    );

    genvar gi;
    generate
        for (gi = 0; gi < NTRIG; gi++) begin : g_slot
            assign dmode_vec[gi] = ctl_arr[gi].dmode;
            if (gi + 1 < NTRIG) begin : g_mid
                assign next_dm[gi] = dmode_vec[gi+1];
            end else begin : g_last
                assign next_dm[gi] = 1'b0;
            end

            dbg_trig_slot u_slot (
                .clk         (clk),
                .rst_n       (rst_n),
                .wr_ctl      (accept && csr_addr == SEL_CTRL  && idx_q == IDX_W'(gi)),
                .wr_mdat     (accept && csr_addr == SEL_MDATA && idx_q == IDX_W'(gi)),
                .wr_ext      (accept && csr_addr == SEL_EXTRA && idx_q == IDX_W'(gi)),
                .wdata       (csr_wdata),
                .next_dmode  (next_dm[gi]),
                .hyp_present (hyp_present),
                .sup_present (sup_present),
                .ctl_o       (ctl_arr[gi]),
                .mdat_o      (mdat_arr[gi]),
                .ext_rd_o    (ext_arr[gi])
            );
        end
    endgenerate

    // Read-data mux for the addressed register of the selected trigger.
    always_comb begin
        unique case (csr_addr)
            SEL_INDEX: csr_rdata = CSR_W'(idx_q);
            SEL_CTRL:  csr_rdata = ctl_pack(ctl_arr[idx_q]);
            SEL_MDATA: csr_rdata = mdat_arr[idx_q];
            default:   csr_rdata = ext_arr[idx_q];
        endcase
    end

    // One-cycle write outcome pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ok      <= 1'b0;
            wr_blocked <= 1'b0;
        end else begin
            wr_ok      <= accept && csr_valid && csr_write;
            wr_blocked <= blocked;
        end
    end
endmodule

// File: rtl/dbg_trig_bank_chk.sv
// Checker: temporal properties of the trigger register bank, bound to the top.
module dbg_trig_bank_chk #(
    parameter int NTRIG = 4,
    parameter int IDX_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             csr_valid,
    input logic             csr_write,
    input logic [1:0]       csr_addr,
    input logic [31:0]      csr_rdata,
    input logic             in_debug,
    input logic             hyp_present,
    input logic             wr_ok,
    input logic             wr_blocked,
    input logic [IDX_W-1:0] idx,
    input logic             sel_dmode
);
    p_pulse_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_ok && wr_blocked));

    p_pulse_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok || wr_blocked) |-> $past(csr_valid && csr_write));

    p_index_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        32'(idx) < NTRIG);

    p_hsel_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_addr == 2'd3) |-> (csr_rdata[25:23] == 3'd0 ||
            (hyp_present && (csr_rdata[25:23] == 3'd2 || csr_rdata[25:23] == 3'd6))));

    p_gap_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_addr == 2'd3) |-> (csr_rdata[22:20] == 3'd0));

    p_ssel_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_addr == 2'd3) |-> (csr_rdata[1:0] == 2'd0 || csr_rdata[1:0] == 2'd2));

    p_action_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_addr == 2'd1) |-> (csr_rdata[15:12] <= 4'd4 &&
            !(csr_rdata[15:12] == 4'd1 && !csr_rdata[27])));

    p_owned_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_valid && csr_write && csr_addr != 2'd0 && sel_dmode && !in_debug)
            |=> (wr_blocked && !wr_ok));
endmodule

bind dbg_trig_bank dbg_trig_bank_chk #(
    .NTRIG (NTRIG),
    .IDX_W (IDX_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .csr_valid   (csr_valid),
    .csr_write   (csr_write),
    .csr_addr    (csr_addr),
    .csr_rdata   (csr_rdata),
    .in_debug    (in_debug),
    .hyp_present (hyp_present),
    .wr_ok       (wr_ok),
    .wr_blocked  (wr_blocked),
    .idx         (idx_q),
    .sel_dmode   (sel_dmode)
);

// File: tb/tb_dbg_trig_bank.sv
module tb_dbg_trig_bank;
    localparam int NT = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_valid = 1'b0;
    logic        csr_write = 1'b0;
    logic [1:0]  csr_addr = 2'd0;
    logic [31:0] csr_wdata = 32'd0;
    logic [31:0] csr_rdata;
    logic        in_debug = 1'b1;
    logic        hyp_present = 1'b1;
    logic        sup_present = 1'b1;
    logic        wr_ok;
    logic        wr_blocked;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Bench model of the requirements.
    int          m_idx;
    logic        m_dm  [NT];
    logic [3:0]  m_act [NT];
    logic        m_ch  [NT];
    logic [31:0] m_md  [NT];
    logic [31:0] m_ext [NT];

    always #2 clk = ~clk;

    dbg_trig_bank #(.NTRIG(NT)) dut (
        .clk(clk), .rst_n(rst_n), .csr_valid(csr_valid), .csr_write(csr_write),
        .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .in_debug(in_debug), .hyp_present(hyp_present), .sup_present(sup_present),
        .wr_ok(wr_ok), .wr_blocked(wr_blocked)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // R4/R5 write legalization of the extra word.
    function automatic logic [31:0] m_wleg(input logic [31:0] w, input logic sup);
        logic [31:0] r;
        r = w & 32'hFF8C_0000;
        if (sup) r[17:2] = w[17:2];
        r[1:0] = (sup && w[1:0] == 2'd2) ? 2'd2 : 2'd0;
        return r;
    endfunction

    // R3 read view of the extra word.
    function automatic logic [31:0] m_rview(input logic [31:0] e, input logic hyp);
        logic [31:0] r;
        r = e;
        if (!(hyp && (e[25:23] == 3'd2 || e[25:23] == 3'd6))) r[25:23] = 3'd0;
        return r;
    endfunction

    function automatic logic [31:0] m_read(input logic [1:0] a);
        logic [31:0] r;
        r = 32'd0;
        case (a)
            2'd0: r = 32'(m_idx);
            2'd1: begin
                r[27] = m_dm[m_idx];
                r[15:12] = m_act[m_idx];
                r[11] = m_ch[m_idx];
            end
            2'd2: r = m_md[m_idx];
            default: r = m_rview(m_ext[m_idx], hyp_present);
        endcase
        return r;
    endfunction

    task automatic wr(input logic [1:0] a, input logic [31:0] d, input string req);
        bit blk;
        logic [3:0] av;
        blk = (a != 2'd0) && m_dm[m_idx] && !in_debug;
        @(negedge clk);
        csr_valid = 1'b1; csr_write = 1'b1; csr_addr = a; csr_wdata = d;
        @(negedge clk);
        chk(wr_ok == !blk, {req, " R10 wr_ok"}, 32'(wr_ok), 32'(!blk));
        chk(wr_blocked == blk, {req, " R10 wr_blocked"}, 32'(wr_blocked), 32'(blk));
        csr_valid = 1'b0; csr_write = 1'b0;
        if (!blk) begin
            case (a)
                2'd0: m_idx = (d >= 32'(NT)) ? NT - 1 : int'(d);
                2'd1: begin
                    av = d[15:12];
                    if (av > 4'd4 || (av == 4'd1 && !d[27])) av = 4'd0;
                    m_ch[m_idx]  = d[11] && !(!d[27] && m_idx + 1 < NT && m_dm[m_idx+1]);
                    m_dm[m_idx]  = d[27];
                    m_act[m_idx] = av;
                    m_ext[m_idx] = m_wleg(m_rview(m_ext[m_idx], hyp_present), sup_present);
                end
                2'd2: m_md[m_idx] = d;
                default: m_ext[m_idx] = m_wleg(d, sup_present);
            endcase
        end
    endtask

    task automatic rd(input logic [1:0] a, input string req);
        logic [31:0] e;
        @(negedge clk);
        csr_addr = a;
        #1;
        e = m_read(a);
        chk(csr_rdata === e, req, csr_rdata, e);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        m_idx = 0;
        for (int i = 0; i < NT; i++) begin
            m_dm[i] = 0; m_act[i] = 0; m_ch[i] = 0; m_md[i] = 0; m_ext[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state
        rd(2'd0, "R11 index");
        for (int t = 0; t < NT; t++) begin
            wr(2'd0, 32'(t), "R11");
            rd(2'd1, "R11 ctrl");
            rd(2'd2, "R11 mdata");
            rd(2'd3, "R11 extra");
        end

        // R1 clamping sweep
        for (int v = 0; v < 10; v++) begin
            wr(2'd0, 32'(v), "R1");
            rd(2'd0, "R1 clamp");
        end
        wr(2'd0, 32'hFFFF_FFFF, "R1");
        rd(2'd0, "R1 clamp max");

        // R1 routing of data accesses
        for (int t = 0; t < NT; t++) begin
            wr(2'd0, 32'(t), "R1");
            wr(2'd2, 32'hA500_0000 ^ (32'(t) * 32'h0101_0101), "R1");
        end
        for (int t = NT - 1; t >= 0; t--) begin
            wr(2'd0, 32'(t), "R1");
            rd(2'd2, "R1 routed mdata");
        end

        // R2/R3 hypervisor select sweep
        for (int h = 0; h < 2; h++) begin
            hyp_present = h[0];
            for (int s = 0; s < 8; s++) begin
                wr(2'd0, 32'(s % NT), "R3");
                wr(2'd3, {6'h15, 3'(s), 3'b111, 2'b10, 16'hBEEF, 2'b00}, "R2");
                rd(2'd3, "R2 R3 extra");
                hyp_present = ~hyp_present;
                rd(2'd3, "R3 read-time view");
                hyp_present = h[0];
            end
        end
        hyp_present = 1'b1;

        // R4/R5 supervisor fields
        for (int sp = 0; sp < 2; sp++) begin
            sup_present = sp[0];
            for (int q = 0; q < 4; q++) begin
                wr(2'd3, {6'h0, 3'h0, 3'h0, 2'b01, 16'h1234 + 16'(q), 2'(q)}, "R5");
                rd(2'd3, "R4 R5 extra");
            end
        end
        sup_present = 1'b1;

        // R6 action legalization sweep
        wr(2'd0, 32'd1, "R6");
        for (int dm = 0; dm < 2; dm++) begin
            for (int a = 0; a < 16; a++) begin
                wr(2'd1, (32'(dm) << 27) | (32'(a) << 12), "R6");
                rd(2'd1, "R6 action");
            end
        end
        wr(2'd1, 32'd0, "R6");

        // R7 chain forcing
        wr(2'd0, 32'd1, "R7");
        wr(2'd1, 32'h0800_0000, "R7");
        wr(2'd0, 32'd0, "R7");
        wr(2'd1, 32'h0000_0800, "R7");
        rd(2'd1, "R7 chain cleared");
        wr(2'd1, 32'h0800_0800, "R7");
        rd(2'd1, "R7 chain kept dmode1");
        wr(2'd1, 32'd0, "R7");
        wr(2'd0, 32'd1, "R7");
        wr(2'd1, 32'd0, "R7");
        wr(2'd0, 32'd0, "R7");
        wr(2'd1, 32'h0000_0800, "R7");
        rd(2'd1, "R7 chain kept next clear");
        wr(2'd0, 32'(NT - 1), "R7");
        wr(2'd1, 32'h0000_0800, "R7");
        rd(2'd1, "R7 chain last trigger");

        // R8 ownership write block
        wr(2'd0, 32'd2, "R8");
        wr(2'd3, 32'h5555_0006, "R8");
        wr(2'd1, 32'h0800_1000, "R8");
        in_debug = 1'b0;
        wr(2'd3, 32'hAAAA_AAAA, "R8");
        rd(2'd3, "R8 extra unchanged");
        wr(2'd2, 32'h1234_5678, "R8");
        rd(2'd2, "R8 mdata unchanged");
        wr(2'd1, 32'd0, "R8");
        rd(2'd1, "R8 ctrl unchanged");
        wr(2'd0, 32'd1, "R8 index free");
        rd(2'd0, "R8 index written");
        wr(2'd3, 32'h0000_0002, "R8 unowned");
        rd(2'd3, "R8 unowned extra");
        wr(2'd0, 32'd2, "R8");
        in_debug = 1'b1;
        wr(2'd3, 32'hAAAA_AAAA, "R8 in debug");
        rd(2'd3, "R8 extra written");
        wr(2'd1, 32'd0, "R8");

        // R9 re-legalization on control write
        wr(2'd0, 32'd3, "R9");
        hyp_present = 1'b1; sup_present = 1'b1;
        wr(2'd3, {6'h3F, 3'd2, 3'd0, 2'b11, 16'hCAFE, 2'd2}, "R9");
        wr(2'd1, 32'd0, "R9");
        rd(2'd3, "R9 kept with extensions");
        hyp_present = 1'b0; sup_present = 1'b0;
        wr(2'd1, 32'd0, "R9");
        hyp_present = 1'b1; sup_present = 1'b1;
        rd(2'd3, "R9 relegalized");
        chk(csr_rdata == {6'h3F, 3'd0, 3'd0, 2'b11, 16'h0, 2'd0}, "R9 literal",
            csr_rdata, {6'h3F, 3'd0, 3'd0, 2'b11, 16'h0, 2'd0});

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule